// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. The caller gives a privilege index, an access mask and the base of the top-level table. The walker then either resolves the address with no memory traffic or walks three levels of 64-bit table entries through a read port.

Two cases resolve at once, with no memory access:
- An address that is not sign-extended is rejected.
- Addresses in the kernel's direct-mapped superpage window are remapped.

Every other address costs three entry reads. After the walk, the result is one of two things. It is either a physical address with the granted read, write and execute rights, or a fault code. Faults cover a missing entry, missing rights and a fault-on-access marking. The walker accepts one request at a time. It pulses `done` when the result is on its outputs and holds that result until the next `done`.

Top module: `pt_walker`

## Requirements
- R1: During and after reset, `busy`, `done`, `mem_req_valid` and `ok` are low.
- R2: If bits 63:43 of the address are not all equal, the walk ends with fault code 0 (access violation). No memory request is made, and `done` is high in the cycle after the start is accepted.
- R3: If bit 63 is set and bits 42:41 are 2'b10, a kernel request (`priv`=0) succeeds with no memory request. The physical address is bits 39:0 of the address, with bit 40 copied to bit 43. `perm` is 3'b111.
- R4: A user request (`priv`=1) that falls in the superpage window of R3 gets fault code 0, with no memory request.
- R5: Each table is indexed by a 10-bit field of the address: bits 42:33 for the first level, 32:23 for the second and 22:13 for the third. Each entry is read at table base + index*8. The first base is `pt_base`. Each later base is entry bits 63:32 shifted left by 13. On success, `paddr` = (third-level bits 63:32 << 13) | address bits 12:0.
- R6: An entry at any level with bit 0 (valid) clear ends the walk with fault code 1.
- R7: A valid first- or second-level entry with bit 8 (kernel read enable) clear ends the walk with fault code 0.
- R8: `need` and `perm` both use bit 0 = read, bit 1 = write, bit 2 = execute. At the third level, read and execute are granted by entry bit 8+`priv`, and write by bit 12+`priv`. If `need` is nonzero and shares no bit with the granted set, the fault code is 0.
- R9: Granted rights are then masked: entry bit 1 clears read, bit 2 clears write and bit 3 clears execute. If `need` is nonzero and none of its bits survive, the fault code is 4 when execute is needed, otherwise 3 when write is needed, otherwise 2.
- R10: With `need` = 0 (probe), a valid walk never faults on rights. It returns `ok` with the masked rights in `perm`.
- R11: `start` is accepted only while `busy` is low, and a `start` seen while busy has no effect. `done` is high only while `busy` is low. The outputs change only in a `done` cycle. A `start` in a `done` cycle is accepted.
- R12: Once raised, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen. Each handshake is answered by exactly one `mem_rsp_valid` beat, and a walk makes exactly three handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (taken when idle) |
| vaddr | input | 64 | Virtual address |
| need | input | 3 | Needed rights: bit0 read, bit1 write, bit2 execute |
| priv | input | 1 | Privilege index: 0 kernel, 1 user |
| pt_base | input | 64 | Base address of the first-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Translation succeeded |
| fault | output | 3 | Fault code: 0 access violation, 1 not valid, 2/3/4 fault on read/write/execute |
| paddr | output | 64 | Physical address (zero on fault) |
| perm | output | 3 | Granted rights, same encoding as `need` (zero on fault) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Table entry |

## Verification
Two events can land on the same clock edge. One is the result strobe of a finished walk. The other is the acceptance of a new `start`. The bench raises `start` exactly in the `done` cycle with a superpage address, which finishes in one cycle. It then requires two back-to-back strobes: the first carrying the finished walk's result, the second the superpage result. A `start` raised mid-walk is also checked: it must leave the request count at three and the result unchanged.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_BITS  = 43,
  parameter int PG_BITS  = 13,
  parameter int IDX_BITS = 10,
  parameter int KRE_BIT  = 8,
  parameter int KWE_BIT  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] vaddr,
  input  logic [2:0]  need,
  input  logic        priv,
  input  logic [63:0] pt_base,
  output logic        busy,
  output logic        done,
  output logic        ok,
  output logic [2:0]  fault,
  output logic [63:0] paddr,
  output logic [2:0]  perm,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data
);
  localparam int SP_SRC = VA_BITS - 3;
  localparam int SP_DST = VA_BITS;
  localparam logic [2:0] F_ACV = 3'd0, F_TNV = 3'd1, F_FOR = 3'd2, F_FOW = 3'd3, F_FOE = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;
  logic [1:0]  lvl;
  logic [63:0] va_q, base_q;
  logic [2:0]  need_q;
  logic        priv_q;

  logic        canon_in, super_in;
  logic [63:0] sp_pa;
  assign canon_in = (&vaddr[63:VA_BITS]) | ~(|vaddr[63:VA_BITS]);
  assign super_in = vaddr[63] & (vaddr[VA_BITS-1 -: 2] == 2'b10);
  assign sp_pa    = 64'(vaddr[SP_SRC-1:0]) | (64'(vaddr[SP_SRC]) << SP_DST);

  logic [IDX_BITS-1:0] idx;
  always_comb begin
    case (lvl)
      2'd0:    idx = va_q[PG_BITS + 3*IDX_BITS - 1 -: IDX_BITS];
      2'd1:    idx = va_q[PG_BITS + 2*IDX_BITS - 1 -: IDX_BITS];
      default: idx = va_q[PG_BITS + IDX_BITS - 1 -: IDX_BITS];
    endcase
  end

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = base_q + 64'({idx, 3'b000});

  logic [63:0] next_base;
  logic        rd_en, wr_en;
  logic [2:0]  grant, kept;
  assign next_base = 64'(mem_rsp_data[63:32]) << PG_BITS;
  assign rd_en = priv_q ? mem_rsp_data[KRE_BIT+1] : mem_rsp_data[KRE_BIT];
  assign wr_en = priv_q ? mem_rsp_data[KWE_BIT+1] : mem_rsp_data[KWE_BIT];
  assign grant = {rd_en, wr_en, rd_en};
  assign kept  = grant & ~mem_rsp_data[3:1];

  logic        fin, f_ok;
  logic [2:0]  f_code, f_pm;
  logic [63:0] f_pa;
  always_comb begin
    fin = 1'b0; f_ok = 1'b0; f_code = F_ACV; f_pa = '0; f_pm = '0;
    case (st)
      S_IDLE: if (start) begin
        if (!canon_in) fin = 1'b1;
        else if (super_in) begin
          fin = 1'b1;
          if (!priv) begin f_ok = 1'b1; f_pa = sp_pa; f_pm = 3'b111; end
        end
      end
      S_WAIT: if (mem_rsp_valid) begin
        if (!mem_rsp_data[0]) begin fin = 1'b1; f_code = F_TNV; end
        else if (lvl != 2'd2) begin
          if (!mem_rsp_data[KRE_BIT]) fin = 1'b1;
        end
        else if (need_q != 3'b000 && (grant & need_q) == 3'b000) fin = 1'b1;
        else if (need_q != 3'b000 && (kept & need_q) == 3'b000) begin
          fin = 1'b1;
          f_code = need_q[2] ? F_FOE : (need_q[1] ? F_FOW : F_FOR);
        end
        else begin
          fin = 1'b1; f_ok = 1'b1; f_pm = kept;
          f_pa = next_base | 64'(va_q[PG_BITS-1:0]);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lvl <= '0; va_q <= '0; base_q <= '0; need_q <= '0; priv_q <= 1'b0;
      done <= 1'b0; ok <= 1'b0; fault <= '0; paddr <= '0; perm <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        ok <= f_ok; fault <= f_code; paddr <= f_pa; perm <= f_pm;
      end
      case (st)
        S_IDLE: if (start) begin
          va_q <= vaddr; need_q <= need; priv_q <= priv;
          if (!fin) begin st <= S_REQ; lvl <= '0; base_q <= pt_base; end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (fin) st <= S_IDLE;
          else begin st <= S_REQ; lvl <= lvl + 2'd1; base_q <= next_base; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^mem_rsp_data;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req_valid); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(paddr) && $stable(ok) && $stable(perm) && $stable(fault)); // R11
  AST_OK_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> (&va_q[63:VA_BITS]) || !(|va_q[63:VA_BITS])); // R2
  AST_OK_HAS_NEED: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && need_q != 3'b000 |-> (perm & need_q) != 3'b000); // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok |-> fault <= F_FOE && paddr == 64'd0); // R6
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, priv;
  logic [63:0] vaddr, pt_base;
  logic [2:0]  need;
  logic        busy, done, ok;
  logic [2:0]  fault, perm;
  logic [63:0] paddr;
  logic        mem_req_valid, mem_req_addr_unused;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .need(need), .priv(priv),
    .pt_base(pt_base), .busy(busy), .done(done), .ok(ok), .fault(fault), .paddr(paddr),
    .perm(perm), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));
  assign mem_req_addr_unused = 1'b0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] alog [8];
  int reqs = 0, rcnt = 0;
  int checks = 0, bad = 0;
  localparam logic [63:0] PT = 64'h1_0000;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    mem_req_ready <= (rcnt % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= rd(mem_req_addr);
      alog[reqs % 8] <= mem_req_addr;
      reqs <= reqs + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [63:0] va, input logic [2:0] nd, input logic pv,
                       output logic e_ok, output logic [2:0] e_code,
                       output logic [63:0] e_pa, output logic [2:0] e_pm);
    logic [63:0] base, pte;
    logic r, w;
    logic [2:0] g, k;
    e_ok = 0; e_code = 0; e_pa = 0; e_pm = 0;
    if (!((&va[63:43]) || !(|va[63:43]))) return;
    if (va[63] && va[42:41] == 2'b10) begin
      if (!pv) begin e_ok = 1; e_pm = 3'b111; e_pa = {20'd0, va[40], 3'd0, va[39:0]}; end
      return;
    end
    base = PT;
    for (int l = 0; l < 2; l++) begin
      pte = rd(base + 64'((l == 0 ? va[42:33] : va[32:23])) * 8);
      if (!pte[0]) begin e_code = 1; return; end
      if (!pte[8]) return;
      base = {19'd0, pte[63:32], 13'd0};
    end
    pte = rd(base + 64'(va[22:13]) * 8);
    if (!pte[0]) begin e_code = 1; return; end
    r = pv ? pte[9] : pte[8];
    w = pv ? pte[13] : pte[12];
    g = {r, w, r};
    if (nd != 0 && (g & nd) == 0) return;
    k = g & ~pte[3:1];
    if (nd != 0 && (k & nd) == 0) begin e_code = nd[2] ? 4 : (nd[1] ? 3 : 2); return; end
    e_ok = 1; e_pm = k; e_pa = {19'd0, pte[63:32], 13'd0} | {51'd0, va[12:0]};
  endtask

  task automatic walk(input logic [63:0] va, input logic [2:0] nd, input logic pv,
                      output int lat);
    @(negedge clk);
    vaddr = va; need = nd; priv = pv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done) begin @(negedge clk); lat++; end
  endtask

  task automatic expect_walk(input string tag, input logic [63:0] va, input logic [2:0] nd,
                             input logic pv);
    logic e_ok; logic [2:0] e_code, e_pm; logic [63:0] e_pa;
    int lat;
    model(va, nd, pv, e_ok, e_code, e_pa, e_pm);
    walk(va, nd, pv, lat);
    chk({tag, " ok"}, 64'(ok), 64'(e_ok));
    chk({tag, " code"}, 64'(fault), 64'(e_code));
    chk({tag, " paddr"}, paddr, e_pa);
    chk({tag, " perm"}, 64'(perm), 64'(e_pm));
  endtask

  localparam logic [63:0] VA = 64'h0000_0006_0280_EABC;
  task automatic build(input logic [31:0] f1, input logic [31:0] f2, input logic [63:0] l3);
    mem.delete();
    mem[PT + 64'h18] = {32'h20, f1};
    mem[64'h4_0028] = {32'h21, f2};
    mem[64'h4_2038] = l3;
  endtask

  task automatic t_reset;
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 req", 64'(mem_req_valid), 0);
    chk("R1 ok", 64'(ok), 0);
  endtask

  task automatic t_basic;
    int r0, lat;
    build(32'h101, 32'h101, {32'h0004_5678, 32'h101});
    r0 = reqs;
    walk(VA, 3'b001, 1'b0, lat);
    chk("R5 paddr", paddr, 64'h8ACF_0ABC);
    chk("R5 ok", 64'(ok), 1);
    chk("R5 perm", 64'(perm), 64'b101);
    chk("R12 count", 64'(reqs - r0), 3);
    chk("R5 addr L1", alog[r0 % 8], PT + 64'h18);
    chk("R5 addr L2", alog[(r0 + 1) % 8], 64'h4_0028);
    chk("R5 addr L3", alog[(r0 + 2) % 8], 64'h4_2038);
  endtask

  task automatic t_perm;
    build(32'h101, 32'h101, {32'h55, 32'h2001});
    expect_walk("R8 user write ok", VA, 3'b010, 1'b1);
    build(32'h101, 32'h101, {32'h55, 32'h1001});
    expect_walk("R8 user write denied", VA, 3'b010, 1'b1);
    expect_walk("R8 kernel write ok", VA, 3'b010, 1'b0);
    build(32'h101, 32'h101, {32'h55, 32'h0201});
    expect_walk("R8 user exec ok", VA, 3'b100, 1'b1);
    expect_walk("R8 kernel read denied", VA, 3'b001, 1'b0);
  endtask

  task automatic t_invalid;
    build(32'h100, 32'h101, {32'h55, 32'h101});
    expect_walk("R6 L1 invalid", VA, 3'b001, 1'b0);
    build(32'h101, 32'h100, {32'h55, 32'h101});
    expect_walk("R6 L2 invalid", VA, 3'b001, 1'b0);
    build(32'h101, 32'h101, {32'h55, 32'h100});
    expect_walk("R6 L3 invalid", VA, 3'b001, 1'b0);
    chk("R6 code value", 64'(fault), 1);
  endtask

  task automatic t_kre;
    build(32'h101, 32'h001, {32'h55, 32'h101});
    expect_walk("R7 L2 no kre", VA, 3'b001, 1'b0);
    build(32'h001, 32'h101, {32'h55, 32'h101});
    expect_walk("R7 L1 no kre", VA, 3'b001, 1'b1);
    chk("R7 code value", 64'(fault), 0);
  endtask

  task automatic t_fault_on;
    build(32'h101, 32'h101, {32'h55, 32'h110F});
    expect_walk("R9 foe", VA, 3'b100, 1'b0);
    chk("R9 foe code", 64'(fault), 4);
    expect_walk("R9 fow", VA, 3'b010, 1'b0);
    chk("R9 fow code", 64'(fault), 3);
    expect_walk("R9 for", VA, 3'b001, 1'b0);
    chk("R9 for code", 64'(fault), 2);
    expect_walk("R9 prio all", VA, 3'b111, 1'b0);
    expect_walk("R9 prio wr", VA, 3'b011, 1'b0);
    build(32'h101, 32'h101, {32'h55, 32'h1103});
    expect_walk("R9 partial keep", VA, 3'b011, 1'b0);
  endtask

  task automatic t_probe;
    build(32'h101, 32'h101, {32'h55, 32'h0001});
    expect_walk("R10 probe none", VA, 3'b000, 1'b0);
    chk("R10 probe ok", 64'(ok), 1);
    build(32'h101, 32'h101, {32'h55, 32'h110B});
    expect_walk("R10 probe masked", VA, 3'b000, 1'b0);
  endtask

  task automatic t_noncanon;
    int r0, lat;
    r0 = reqs;
    walk(64'h0000_0800_0000_0000, 3'b001, 1'b0, lat);
    chk("R2 latency", 64'(lat), 1);
    chk("R2 ok", 64'(ok), 0);
    chk("R2 code", 64'(fault), 0);
    chk("R2 no mem", 64'(reqs - r0), 0);
    expect_walk("R2 high", 64'hFFF0_0000_0000_0000, 3'b000, 1'b0);
  endtask

  task automatic t_super;
    int r0, lat;
    r0 = reqs;
    walk(64'hFFFF_FD12_3456_789A, 3'b010, 1'b0, lat);
    chk("R3 paddr", paddr, 64'h0000_0812_3456_789A);
    chk("R3 perm", 64'(perm), 64'b111);
    chk("R3 ok", 64'(ok), 1);
    chk("R3 latency", 64'(lat), 1);
    walk(64'hFFFF_FC00_0000_4000, 3'b001, 1'b0, lat);
    chk("R3 bit40 clear", paddr, 64'h0000_0000_0000_4000);
    walk(64'hFFFF_FD12_3456_789A, 3'b001, 1'b1, lat);
    chk("R4 ok", 64'(ok), 0);
    chk("R4 code", 64'(fault), 0);
    chk("R4 no mem", 64'(reqs - r0), 0);
  endtask

  task automatic t_busy_start;
    int r0;
    build(32'h101, 32'h101, {32'h0004_5678, 32'h101});
    r0 = reqs;
    @(negedge clk);
    vaddr = VA; need = 3'b001; priv = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    vaddr = 64'hFFFF_FD12_3456_789A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 busy start ignored", paddr, 64'h8ACF_0ABC);
    chk("R11 req count", 64'(reqs - r0), 3);
    @(negedge clk);
    chk("R11 no extra done", 64'(done), 0);
    chk("R11 idle", 64'(busy), 0);
  endtask

  task automatic t_done_start;
    @(negedge clk);
    vaddr = VA; need = 3'b001; priv = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 first result", paddr, 64'h8ACF_0ABC);
    vaddr = 64'hFFFF_FD12_3456_789A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 second done", 64'(done), 1);
    chk("R11 second result", paddr, 64'h0000_0812_3456_789A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vaddr = '0; need = '0; priv = 1'b0; pt_base = PT;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_perm();
    t_invalid();
    t_kre();
    t_fault_on();
    t_probe();
    t_noncanon();
    t_super();
    t_busy_start();
    t_done_start();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule